// File: doc/BRIEF.md
# Half-Pixel Overlay Control Aligner

This block lines up two overlay control bits with a YUV pixel bus. The two bits are a fast-blanking flag and a peaking-off flag. It runs on a clock at twice the pixel rate, so each clock tick is half a pixel. A pixel strobe marks the ticks where a new pixel begins. The YUV bus always passes through a fixed delay of two ticks. The two control bits pass through a delay chosen by a 2-bit shift code. The code can put the controls exactly in line with the video, let them lag by half a pixel or a whole pixel, or let them lead by half a pixel.

The fixed delay on the video path is what makes a leading shift possible. The control bits can then arrive one tick before their matching pixel without the block having to look ahead. The shift code is sampled only on ticks where the pixel strobe is high. A code change therefore always lands on a pixel boundary, and a control pulse is never stretched or cut unevenly in the middle of a pixel.

Top module: `hp_ctrl_aligner`

## Requirements
- R1: `yuv_out` equals the `yuv_in` value sampled two clock edges earlier, whatever the shift code.
- R2: With active code 00, both control outputs equal their inputs as sampled two edges earlier, which is the same alignment as the video.
- R3: With active code 01, the control outputs equal their inputs as sampled three edges earlier, so they lag the video by half a pixel.
- R4: With active code 10, the control outputs equal their inputs as sampled one edge earlier, so they lead the video by half a pixel.
- R5: With active code 11, the control outputs equal their inputs as sampled four edges earlier, so they lag the video by one full pixel.
- R6: The fast-blanking and peaking-off bits always share the same delay, and each output depends only on its own input.
- R7: `shift_code` is loaded into the active code only on a clock edge where `pix_en` is high, and takes effect on the following cycle. A code presented while `pix_en` is low has no effect on the outputs.
- R8: While `rst` is high, every delay stage clears to 0 and the active code returns to 00. The cycle after a reset edge, `fbl_out`, `pko_out` and `yuv_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the pixel rate |
| rst | input | 1 | Synchronous reset, active high |
| pix_en | input | 1 | Pixel boundary strobe; qualifies loading of the shift code |
| shift_code | input | 2 | Requested control shift: 00 align, 01 lag half, 10 lead half, 11 lag full |
| fbl_in | input | 1 | Fast-blanking control input |
| pko_in | input | 1 | Peaking-off control input |
| yuv_in | input | CH_BITS*N_CH (24) | YUV pixel bus input |
| yuv_out | output | CH_BITS*N_CH (24) | YUV bus delayed by two ticks |
| fbl_out | output | 1 | Shifted fast-blanking control |
| pko_out | output | 1 | Shifted peaking-off control |

## Verification
The bench tests the leading code. A design that tapped the wrong stage there would put out the control one tick late, or in step with the video, instead of ahead of it. It also changes the code while the strobe is held low. A latch that ignored the strobe would then switch delay in mid-pixel and shift the controls at once. The bench drives the two control bits with patterns that differ and with single-tick pulses. This exposes swapped bits and a wrong tap for either bit. Resets applied while the pipeline is full catch stages or a code register that keep stale values.

// File: rtl/hp_align_pkg.sv
package hp_align_pkg;

    localparam int unsigned MAX_DELAY = 4;
    localparam int unsigned YUV_DELAY = 2;
    localparam int unsigned TAP_W     = $clog2(MAX_DELAY);

    typedef enum logic [1:0] {
        SHIFT_ALIGN     = 2'b00,
        SHIFT_LAG_HALF  = 2'b01,
        SHIFT_LEAD_HALF = 2'b10,
        SHIFT_LAG_FULL  = 2'b11
    } shift_e;

    typedef struct packed {
        logic pko;
        logic fbl;
    } ovl_ctrl_t;

    localparam int unsigned CTRL_W = $bits(ovl_ctrl_t);

    // Total control delay in half-pixel ticks: base video delay plus signed shift.
    function automatic int unsigned ctrl_delay(input shift_e code);
        case (code)
            SHIFT_ALIGN:     return YUV_DELAY;
            SHIFT_LAG_HALF:  return YUV_DELAY + 1;
            SHIFT_LEAD_HALF: return YUV_DELAY - 1;
            default:         return YUV_DELAY + 2;
        endcase
    endfunction

    // Tap index into a delay line whose stage k holds the input delayed k+1 ticks.
    function automatic logic [TAP_W-1:0] tap_index(input shift_e code);
        int unsigned d;
        d = ctrl_delay(code);
        return TAP_W'(d - 1);
    endfunction

endpackage

// File: rtl/hp_code_latch.sv
module hp_code_latch
    import hp_align_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  shift_e code_in,
    output shift_e code_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= SHIFT_ALIGN;
        end else if (load) begin
            code_q <= code_in;
        end
    end

endmodule

// File: rtl/hp_delay_line.sv
module hp_delay_line #(
    parameter int unsigned W     = 2,
    parameter int unsigned DEPTH = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [W-1:0]              din,
    output logic [DEPTH-1:0][W-1:0]   taps
);

    generate
        for (genvar k = 0; k < DEPTH; k++) begin : g_stage
            if (k == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) taps[k] <= '0;
                    else     taps[k] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) taps[k] <= '0;
                    else     taps[k] <= taps[k-1];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/hp_tap_mux.sv
module hp_tap_mux #(
    parameter int unsigned W     = 2,
    parameter int unsigned DEPTH = 4,
    localparam int unsigned SEL_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0][W-1:0] taps,
    input  logic [SEL_W-1:0]        sel,
    output logic [W-1:0]            dout
);

    always_comb begin
        dout = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (int'(sel) == k) dout = taps[k];
        end
    end

endmodule

// File: rtl/hp_ctrl_aligner.sv
module hp_ctrl_aligner
    import hp_align_pkg::*;
#(
    parameter int unsigned CH_BITS = 8,
    parameter int unsigned N_CH    = 3,
    localparam int unsigned YUV_W  = CH_BITS * N_CH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pix_en,
    input  logic [1:0]       shift_code,
    input  logic             fbl_in,
    input  logic             pko_in,
    input  logic [YUV_W-1:0] yuv_in,
    output logic [YUV_W-1:0] yuv_out,
    output logic             fbl_out,
    output logic             pko_out
);

    shift_e                          code_q;
    ovl_ctrl_t                       ctrl_in;
    ovl_ctrl_t                       ctrl_sel;
    logic [MAX_DELAY-1:0][CTRL_W-1:0] ctrl_taps;
    logic [YUV_DELAY-1:0][YUV_W-1:0]  yuv_taps;
    logic [TAP_W-1:0]                tap_sel;

    assign ctrl_in.fbl = fbl_in;
    assign ctrl_in.pko = pko_in;

    hp_code_latch u_code (
        .clk     (clk),
        .rst     (rst),
        .load    (pix_en),
        .code_in (shift_e'(shift_code)),
        .code_q  (code_q)
    );

    hp_delay_line #(.W(CTRL_W), .DEPTH(MAX_DELAY)) u_ctrl_dly (
        .clk  (clk),
        .rst  (rst),
        .din  (ctrl_in),
        .taps (ctrl_taps)
    );

    hp_delay_line #(.W(YUV_W), .DEPTH(YUV_DELAY)) u_yuv_dly (
        .clk  (clk),
        .rst  (rst),
        .din  (yuv_in),
        .taps (yuv_taps)
    );

    assign tap_sel = tap_index(code_q);

    hp_tap_mux #(.W(CTRL_W), .DEPTH(MAX_DELAY)) u_ctrl_mux (
        .taps (ctrl_taps),
        .sel  (tap_sel),
        .dout (ctrl_sel)
    );

    assign yuv_out = yuv_taps[YUV_DELAY-1];
    assign fbl_out = ctrl_sel.fbl;
    assign pko_out = ctrl_sel.pko;

endmodule

module hp_ctrl_aligner_chk #(
    parameter int unsigned YUV_W = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             pix_en,
    input logic [1:0]       shift_code,
    input logic [1:0]       act_code,
    input logic             fbl_in,
    input logic             pko_in,
    input logic [YUV_W-1:0] yuv_in,
    input logic [YUV_W-1:0] yuv_out,
    input logic             fbl_out,
    input logic             pko_out
);

    logic [2:0] warm_cnt;
    logic       warm;

    always_ff @(posedge clk) begin
        if (rst)                 warm_cnt <= '0;
        else if (warm_cnt != 3'd7) warm_cnt <= warm_cnt + 3'd1;
    end
    assign warm = (warm_cnt >= 3'd4);

    a_r1_yuv_delay: assert property (@(posedge clk) disable iff (rst)
        warm |-> (yuv_out == $past(yuv_in, 2)));

    a_r2_align: assert property (@(posedge clk) disable iff (rst)
        (warm && act_code == 2'b00) |->
            (fbl_out == $past(fbl_in, 2) && pko_out == $past(pko_in, 2)));

    a_r3_lag_half: assert property (@(posedge clk) disable iff (rst)
        (warm && act_code == 2'b01) |->
            (fbl_out == $past(fbl_in, 3) && pko_out == $past(pko_in, 3)));

    a_r4_lead_half: assert property (@(posedge clk) disable iff (rst)
        (warm && act_code == 2'b10) |->
            (fbl_out == $past(fbl_in, 1) && pko_out == $past(pko_in, 1)));

    a_r5_lag_full: assert property (@(posedge clk) disable iff (rst)
        (warm && act_code == 2'b11) |->
            (fbl_out == $past(fbl_in, 4) && pko_out == $past(pko_in, 4)));

    a_r7_code_hold: assert property (@(posedge clk) disable iff (rst)
        !pix_en |=> (act_code == $past(act_code)));

    a_r7_code_load: assert property (@(posedge clk) disable iff (rst)
        pix_en |=> (act_code == $past(shift_code)));

    a_r8_reset_clear: assert property (@(posedge clk)
        rst |=> (!fbl_out && !pko_out && yuv_out == '0 && act_code == 2'b00));

endmodule

bind hp_ctrl_aligner hp_ctrl_aligner_chk #(.YUV_W(YUV_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pix_en     (pix_en),
    .shift_code (shift_code),
    .act_code   (code_q),
    .fbl_in     (fbl_in),
    .pko_in     (pko_in),
    .yuv_in     (yuv_in),
    .yuv_out    (yuv_out),
    .fbl_out    (fbl_out),
    .pko_out    (pko_out)
);

// File: tb/tb_hp_ctrl_aligner.sv
module tb_hp_ctrl_aligner;

    localparam int YW = 24;

    logic          clk = 1'b0;
    logic          rst;
    logic          pix_en;
    logic [1:0]    shift_code;
    logic          fbl_in;
    logic          pko_in;
    logic [YW-1:0] yuv_in;
    logic [YW-1:0] yuv_out;
    logic          fbl_out;
    logic          pko_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Reference state: history of {pko, fbl, yuv} samples, newest first.
    logic [YW+1:0] hist [0:4];
    int            m_code;
    string         phase = "R8";

    always #4 clk = ~clk;

    hp_ctrl_aligner dut (
        .clk        (clk),
        .rst        (rst),
        .pix_en     (pix_en),
        .shift_code (shift_code),
        .fbl_in     (fbl_in),
        .pko_in     (pko_in),
        .yuv_in     (yuv_in),
        .yuv_out    (yuv_out),
        .fbl_out    (fbl_out),
        .pko_out    (pko_out)
    );

    function automatic int delay_for(input int code);
        case (code)
            0: return 2;
            1: return 3;
            2: return 1;
            default: return 4;
        endcase
    endfunction

    function automatic string code_tag(input int code);
        case (code)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input string req, input logic [YW-1:0] act, input logic [YW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual=%h expected=%h", req, $time, act, exp);
        end
    endtask

    task automatic step();
        int d;
        string tag;
        @(posedge clk);
        if (rst) begin
            for (int k = 0; k < 5; k++) hist[k] = '0;
            m_code = 0;
        end else begin
            for (int k = 4; k > 0; k--) hist[k] = hist[k-1];
            hist[0] = {pko_in, fbl_in, yuv_in};
            if (pix_en) m_code = int'(shift_code);
        end
        @(negedge clk);
        d   = delay_for(m_code);
        tag = (phase == "") ? code_tag(m_code) : phase;
        check("R1", yuv_out, hist[1][YW-1:0]);
        check(tag, {23'd0, fbl_out}, {23'd0, hist[d-1][YW]});
        check((phase == "") ? "R6" : phase, {23'd0, pko_out}, {23'd0, hist[d-1][YW+1]});
    endtask

    task automatic drive_rand(input bit strobe);
        fbl_in = 1'($urandom);
        pko_in = 1'($urandom);
        yuv_in = YW'($urandom);
        pix_en = strobe;
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        if (!done) begin
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; pix_en = 1'b0; shift_code = 2'b00;
        fbl_in = 1'b1; pko_in = 1'b1; yuv_in = '1;
        for (int k = 0; k < 5; k++) hist[k] = '0;
        m_code = 0;

        // R8: reset state
        phase = "R8";
        for (int i = 0; i < 3; i++) step();
        check("R8", {22'd0, fbl_out, pko_out}, 24'd0);
        check("R8", yuv_out, '0);

        @(negedge clk); rst = 1'b0;

        // R2..R5: each code with random traffic and a regular strobe
        phase = "";
        for (int c = 0; c < 4; c++) begin
            shift_code = 2'(c);
            for (int i = 0; i < 60; i++) begin
                drive_rand(i[0] == 1'b0);
                step();
            end
        end

        // R4: lone single-tick pulse under the leading code
        shift_code = 2'b10;
        pix_en = 1'b1; fbl_in = 1'b0; pko_in = 1'b0; step();
        pix_en = 1'b0;
        for (int i = 0; i < 3; i++) step();
        fbl_in = 1'b1; pko_in = 1'b1; step();
        fbl_in = 1'b0; pko_in = 1'b0;
        for (int i = 0; i < 6; i++) step();

        // R7: code changes while strobe low must not apply
        phase = "R7";
        pix_en = 1'b1; shift_code = 2'b00; step();
        pix_en = 1'b0;
        for (int c = 1; c < 4; c++) begin
            shift_code = 2'(c);
            for (int i = 0; i < 8; i++) begin
                fbl_in = 1'($urandom); pko_in = 1'($urandom); yuv_in = YW'($urandom);
                step();
            end
        end
        // now strobe once with code 11; new delay from next cycle
        pix_en = 1'b1; shift_code = 2'b11; step();
        pix_en = 1'b0; shift_code = 2'b01;
        for (int i = 0; i < 10; i++) begin
            fbl_in = 1'($urandom); pko_in = 1'($urandom);
            step();
        end

        // R6: complementary and independent patterns on the two bits
        phase = "R6";
        for (int c = 0; c < 4; c++) begin
            shift_code = 2'(c);
            for (int i = 0; i < 24; i++) begin
                pix_en = i[0];
                fbl_in = (i % 5 == 0);
                pko_in = (i % 3 == 1);
                yuv_in = YW'(i * 97);
                step();
            end
        end

        // R8: reset with a loaded pipeline and non-default code
        shift_code = 2'b11; pix_en = 1'b1;
        for (int i = 0; i < 6; i++) begin
            fbl_in = 1'b1; pko_in = 1'b1; yuv_in = '1; step();
        end
        phase = "R8";
        rst = 1'b1; step();
        check("R8", {22'd0, fbl_out, pko_out}, 24'd0);
        check("R8", yuv_out, '0);
        rst = 1'b0; pix_en = 1'b0; fbl_in = 1'b0; pko_in = 1'b0; yuv_in = '0;
        for (int i = 0; i < 6; i++) step();

        // mixed irregular strobe run
        phase = "";
        for (int i = 0; i < 400; i++) begin
            shift_code = 2'($urandom);
            drive_rand(1'($urandom));
            step();
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule